// File: doc/BRIEF.md
# Alternating-Slot Frame Transmit Engine

This block sends one frame out of the transmit area of a shared packet SRAM each time the host asks for it. The host programs a 16-bit frame length through two byte-wide register slots, then writes the start bit in a control register. The engine walks a private read pointer through the transmit area (3072 bytes, addresses 0x000 to 0xBFF, wrapping back to zero), fetches one byte per cycle over a synchronous SRAM read port and forwards each byte on a byte-valid stream with first and last markers. It does no framing and no CRC work.

When a frame ends, the read pointer is rounded up to an even address and stored, so the next frame starts on a 16-bit boundary. Completion is reported in two alternating end-of-frame flags, one per packet slot, which the host clears by reading the status register or by writing ones to them. Each completion also sets a sticky transmit-done interrupt flag. The interrupt line is that flag gated by a host mask.

Top module: `tx_req_engine`

## Requirements
- R1: Writing a byte with bit 0 set to the control index 0x02 while the engine is idle starts a frame. Reading index 0x02 returns 1 in bit 0 while the frame is in progress and 0 once it has completed.
- R2: The frame length is a 16-bit register with its low byte at index 0xFC and its high byte at 0xFD, both readable. A frame carries exactly min(length, 3072) bytes.
- R3: Bytes are fetched at ascending addresses from the stored read pointer, and the address after 0xBFF is 0x000. Every byte appears on tx_data with tx_valid high. tx_first marks the first byte of the frame and tx_last marks the final byte.
- R4: After each frame the read pointer becomes the address after the last byte, rounded up to an even value, and 0xC00 becomes 0x000. Index 0x22 reads pointer bits 7:0 and index 0x23 reads bits 15:8. The pointer is 0 after reset.
- R5: In the status register (index 0x01), the first completion after reset sets bit 2 and the next sets bit 3. Later completions keep alternating between the two bits.
- R6: A read of index 0x01 returns the flags and then clears bits 2 and 3. Writing 1 to bit 2 or bit 3 of index 0x01 clears that bit.
- R7: Every completion sets bit 1 of the interrupt status register (index 0xFE). Writing 1 to that bit clears it.
- R8: irq is high exactly when the bitwise AND of interrupt status bits 1:0 and mask bits 1:0 is nonzero. The mask register is at index 0xFF, 8 bits wide and readable.
- R9: A start request written while a frame is in progress has no effect. No second frame follows, and only one completion flag is set.
- R10: A length of zero completes the request with no byte on the stream. The pointer is still re-aligned, and the status and interrupt flags are set as for any other frame.
- R11: After reset, the control, status, pointer and interrupt status registers read 0, irq is low and tx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (the clear-on-read side effect takes place at the clock edge) |
| reg_idx | input | 8 | Host register index |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from reg_idx |
| mem_rd_en | output | 1 | SRAM read enable |
| mem_addr | output | 12 | SRAM byte address |
| mem_rdata | input | 8 | SRAM read data, valid one cycle after mem_rd_en |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of the frame |
| tx_last | output | 1 | Final byte of the frame |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest cases to reach from the ports are a frame that runs across the end of the transmit area, and a frame whose rounded-up end pointer lands exactly on 0xC00. The pointer can only be moved by sending frames, so the stimulus chains frames of chosen lengths. One frame brings the pointer to 3000. A 101-byte frame then wraps and ends on an odd address. A length above the cap follows, and then a 3041-byte frame that ends at 0xBFF. A repeated start bit written in the middle of a long frame shows whether requests made while busy are dropped.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int LEN_W = 16;

    localparam logic [7:0] IDX_STAT   = 8'h01;
    localparam logic [7:0] IDX_CTRL   = 8'h02;
    localparam logic [7:0] IDX_PTR_LO = 8'h22;
    localparam logic [7:0] IDX_PTR_HI = 8'h23;
    localparam logic [7:0] IDX_LEN_LO = 8'hFC;
    localparam logic [7:0] IDX_LEN_HI = 8'hFD;
    localparam logic [7:0] IDX_ISR    = 8'hFE;
    localparam logic [7:0] IDX_MASK   = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/txq_fetch.sv
module txq_fetch
    import txq_pkg::*;
#(
    parameter int REGION_BYTES = 3072,
    parameter int MAX_FETCH    = 3072,
    localparam int AW          = $clog2(REGION_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [AW-1:0]    rptr_o,
    output logic             mem_rd_en_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic [7:0]       mem_rdata_i,
    output logic             tx_valid_o,
    output logic [7:0]       tx_data_o,
    output logic             tx_first_o,
    output logic             tx_last_o
);
    localparam logic [LEN_W-1:0] CAP       = LEN_W'(MAX_FETCH);
    localparam logic [AW-1:0]    LAST_ADDR = AW'(REGION_BYTES - 1);
    localparam logic [AW:0]      WRAP_AT   = (AW+1)'(REGION_BYTES);

    typedef struct packed {
        fetch_st_e        st;
        logic [AW-1:0]    addr;
        logic [AW-1:0]    rptr;
        logic [LEN_W-1:0] remain;
        logic             first;
        logic             vld;
        logic             ofirst;
        logic             olast;
    } fetch_s;

    fetch_s q, d;
    logic [LEN_W-1:0] eff_len;
    logic [AW:0]      bump;
    logic [AW-1:0]    aligned;

    always_comb begin
        eff_len = (len_i > CAP) ? CAP : len_i;

        bump    = {1'b0, q.addr} + {{AW{1'b0}}, 1'b1};
        bump[0] = 1'b0;
        aligned = (bump == WRAP_AT) ? '0 : bump[AW-1:0];

        d           = q;
        d.vld       = 1'b0;
        d.ofirst    = 1'b0;
        d.olast     = 1'b0;
        mem_rd_en_o = 1'b0;
        mem_addr_o  = q.addr;
        done_o      = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.remain = eff_len;
                    d.addr   = q.rptr;
                    d.first  = 1'b1;
                    d.st     = (eff_len == '0) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                mem_rd_en_o = 1'b1;
                d.vld       = 1'b1;
                d.ofirst    = q.first;
                d.olast     = (q.remain == LEN_W'(1));
                d.first     = 1'b0;
                d.addr      = (q.addr == LAST_ADDR) ? '0 : q.addr + AW'(1);
                d.remain    = q.remain - LEN_W'(1);
                if (q.remain == LEN_W'(1)) d.st = ST_FIN;
            end
            ST_FIN: begin
                done_o = 1'b1;
                d.rptr = aligned;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, addr: '0, rptr: '0, remain: '0,
                   first: 1'b0, vld: 1'b0, ofirst: 1'b0, olast: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign rptr_o     = q.rptr;
    assign tx_valid_o = q.vld;
    assign tx_data_o  = q.vld ? mem_rdata_i : 8'h00;
    assign tx_first_o = q.ofirst;
    assign tx_last_o  = q.olast;
endmodule

// File: rtl/txq_regs.sv
module txq_regs
    import txq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [7:0]       idx_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic [AW-1:0]    rptr_i,
    output logic             start_o,
    output logic [LEN_W-1:0] len_o,
    output logic             txf_o,
    output logic [7:0]       mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [7:0]       mask;
        logic [1:0]       endf;
        logic             slot;
        logic             txf;
    } regs_s;

    regs_s q, d;
    logic [15:0] rptr_w;
    logic [1:0]  isr_lo;

    always_comb begin
        rptr_w  = 16'(rptr_i);
        start_o = wr_i && (idx_i == IDX_CTRL) && wdata_i[0] && !busy_i;

        d = q;
        if (wr_i) begin
            unique case (idx_i)
                IDX_LEN_LO: d.len[7:0]  = wdata_i;
                IDX_LEN_HI: d.len[15:8] = wdata_i;
                IDX_MASK:   d.mask      = wdata_i;
                IDX_STAT:   d.endf      = q.endf & ~wdata_i[3:2];
                IDX_ISR:    d.txf       = q.txf & ~wdata_i[1];
                default: ;
            endcase
        end
        if (rd_i && (idx_i == IDX_STAT)) d.endf = 2'b00;
        if (done_i) begin
            d.endf[q.slot] = 1'b1;
            d.slot         = ~q.slot;
            d.txf          = 1'b1;
        end

        unique case (idx_i)
            IDX_STAT:   rdata_o = {4'b0000, q.endf, 2'b00};
            IDX_CTRL:   rdata_o = {7'b0000000, busy_i};
            IDX_PTR_LO: rdata_o = rptr_w[7:0];
            IDX_PTR_HI: rdata_o = rptr_w[15:8];
            IDX_LEN_LO: rdata_o = q.len[7:0];
            IDX_LEN_HI: rdata_o = q.len[15:8];
            IDX_ISR:    rdata_o = {6'b000000, q.txf, 1'b0};
            IDX_MASK:   rdata_o = q.mask;
            default:    rdata_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign isr_lo = {q.txf, 1'b0};
    assign irq_o  = |(isr_lo & q.mask[1:0]);
    assign len_o  = q.len;
    assign txf_o  = q.txf;
    assign mask_o = q.mask;
endmodule

// File: rtl/tx_req_engine.sv
module tx_req_engine
    import txq_pkg::*;
#(
    parameter int REGION_BYTES = 3072,
    parameter int MAX_FETCH    = 3072,
    localparam int AW          = $clog2(REGION_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_idx,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_first,
    output logic          tx_last,
    output logic          irq
);
    logic             start;
    logic             busy;
    logic             done;
    logic [AW-1:0]    rptr;
    logic [LEN_W-1:0] len;
    logic             txf;
    logic [7:0]       mask;

    txq_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .idx_i   (reg_idx),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .busy_i  (busy),
        .done_i  (done),
        .rptr_i  (rptr),
        .start_o (start),
        .len_o   (len),
        .txf_o   (txf),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    txq_fetch #(.REGION_BYTES(REGION_BYTES), .MAX_FETCH(MAX_FETCH)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .len_i       (len),
        .busy_o      (busy),
        .done_o      (done),
        .rptr_o      (rptr),
        .mem_rd_en_o (mem_rd_en),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .tx_valid_o  (tx_valid),
        .tx_data_o   (tx_data),
        .tx_first_o  (tx_first),
        .tx_last_o   (tx_last)
    );
endmodule

// File: rtl/tx_req_engine_chk.sv
module tx_req_engine_chk #(
    parameter int REGION_BYTES = 3072,
    localparam int AW          = $clog2(REGION_BYTES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          busy,
    input logic [AW-1:0] rptr,
    input logic          txf,
    input logic [7:0]    mask,
    input logic          tx_valid,
    input logic          tx_last,
    input logic          tx_first,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_addr,
    input logic          irq
);
    assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last || tx_first) |-> tx_valid);

    assert_addr_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_addr) < REGION_BYTES));

    assert_even_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rptr[0]);

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> txf);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (txf && mask[1]));

    assert_stream_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind tx_req_engine tx_req_engine_chk #(.REGION_BYTES(REGION_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .busy      (busy),
    .rptr      (rptr),
    .txf       (txf),
    .mask      (mask),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .tx_first  (tx_first),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .irq       (irq)
);

// File: tb/tx_req_engine_bench.sv
module tx_req_engine_bench;
    localparam int REGION = 3072;
    localparam int CAPB   = 3072;
    localparam int PER    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_idx = 8'h00, reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        tx_valid, tx_first, tx_last, irq;
    logic [7:0]  tx_data;

    int total = 0;
    int bad   = 0;
    int mdl_ptr  = 0;
    int mdl_slot = 0;
    logic [9:0] expq[$];

    always #(PER/2) clk = ~clk;

    tx_req_engine u_tx_req_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
        .tx_last(tx_last), .irq(irq)
    );

    function automatic logic [7:0] pat(input int a);
        logic [11:0] x;
        x = 12'(a);
        return x[7:0] ^ {x[3:0], x[11:8]};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(int'(mem_addr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected stream items
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R9 unexpected byte", int'(tx_data), -1);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                chk({tx_first, tx_last, tx_data} == e, "R3 stream byte",
                    int'({tx_first, tx_last, tx_data}), int'(e));
            end
        end
    end

    task automatic wr(input logic [7:0] idx, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        rd(8'h02, v);
        while (v[0]) rd(8'h02, v);
    endtask

    // driver: predicts the frame, pushes it, programs and starts it
    task automatic send(input int len, input string req);
        int n, a;
        logic [7:0] v;
        n = (len > CAPB) ? CAPB : len;
        a = mdl_ptr;
        for (int i = 0; i < n; i++) begin
            expq.push_back({(i == 0), (i == n - 1), pat(a)});
            a = (a == REGION - 1) ? 0 : a + 1;
        end
        a = (a + 1) & ~1;
        if (a == REGION) a = 0;
        mdl_ptr = a;
        wr(8'hFC, 8'(len));
        wr(8'hFD, 8'(len >> 8));
        wr(8'h02, 8'h01);
        wait_idle();
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, {req, " all bytes sent"}, expq.size(), 0);
        rd(8'h22, v); chk(v == 8'(mdl_ptr), {req, " R4 ptr lo"}, v, mdl_ptr & 255);
        rd(8'h23, v); chk(v == 8'(mdl_ptr >> 8), {req, " R4 ptr hi"}, v, mdl_ptr >> 8);
    endtask

    task automatic check_stat(input string req);
        logic [7:0] v, e;
        e = (mdl_slot == 0) ? 8'h04 : 8'h08;
        rd(8'h01, v); chk(v == e, {req, " R5 slot flag"}, v, e);
        rd(8'h01, v); chk(v == 8'h00, {req, " R6 clear on read"}, v, 0);
        mdl_slot ^= 1;
    endtask

    initial begin
        #(PER * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        rd(8'h02, v); chk(v == 8'h00, "R11 ctrl", v, 0);
        rd(8'h01, v); chk(v == 8'h00, "R11 stat", v, 0);
        rd(8'h22, v); chk(v == 8'h00, "R11 ptr lo", v, 0);
        rd(8'h23, v); chk(v == 8'h00, "R11 ptr hi", v, 0);
        rd(8'hFE, v); chk(v == 8'h00, "R11 isr", v, 0);
        chk(!irq && !tx_valid, "R11 irq/valid low", {irq, tx_valid}, 0);

        wr(8'hFF, 8'h02);
        rd(8'hFF, v); chk(v == 8'h02, "R8 mask readback", v, 2);

        // R1 busy flag seen during a frame
        wr(8'hFC, 8'd40); wr(8'hFD, 8'd0);
        mdl_ptr = 0;
        for (int i = 0; i < 40; i++) expq.push_back({(i == 0), (i == 39), pat(i)});
        wr(8'h02, 8'h01);
        rd(8'h02, v); chk(v == 8'h01, "R1 busy during frame", v, 1);
        wait_idle();
        mdl_ptr = 40;
        chk(expq.size() == 0, "R1 frame sent", expq.size(), 0);
        check_stat("R5 first");
        rd(8'hFE, v); chk(v == 8'h02, "R7 isr set", v, 2);
        @(negedge clk); chk(irq == 1'b1, "R8 irq high", irq, 1);
        wr(8'hFE, 8'h02);
        rd(8'hFE, v); chk(v == 8'h00, "R7 isr cleared", v, 0);
        @(negedge clk); chk(irq == 1'b0, "R8 irq low after clear", irq, 0);

        send(7, "R4 odd end");          // 40+7=47 -> 48
        check_stat("R5 second");
        send(3000 - 48, "R3 long");     // ends at 3000
        wr(8'h01, 8'h04);
        rd(8'h01, v); chk(v == 8'h00, "R6 write-one clear", v, 0);
        mdl_slot ^= 1;
        @(negedge clk); chk(irq == 1'b1, "R8 irq masked in", irq, 1);
        wr(8'hFF, 8'h00);
        @(negedge clk); chk(irq == 1'b0, "R8 irq masked out", irq, 0);
        wr(8'hFF, 8'h02);
        wr(8'hFE, 8'h02);

        send(101, "R3 wrap");           // ptr 30
        check_stat("R5 third");
        send(5000, "R2 capped");        // 3072 bytes, ptr 30
        rd(8'hFC, v); chk(v == 8'h88, "R2 len lo readback", v, 8'h88);
        rd(8'hFD, v); chk(v == 8'h13, "R2 len hi readback", v, 8'h13);
        check_stat("R5 fourth");
        send(3041, "R4 wrap to zero");  // ptr 0
        chk(mdl_ptr == 0, "R4 model zero", mdl_ptr, 0);
        check_stat("R5 fifth");
        wr(8'hFE, 8'h02);
        send(0, "R10 zero length");
        check_stat("R10 flag");
        rd(8'hFE, v); chk(v == 8'h02, "R10 isr set", v, 2);

        // R9: second request while busy
        wr(8'hFC, 8'd200); wr(8'hFD, 8'd0);
        for (int i = 0; i < 200; i++) expq.push_back({(i == 0), (i == 199), pat(i)});
        wr(8'h02, 8'h01);
        repeat (20) @(negedge clk);
        wr(8'h02, 8'h01);
        wait_idle();
        repeat (40) @(negedge clk);
        mdl_ptr = 200;
        chk(expq.size() == 0, "R9 frame sent once", expq.size(), 0);
        rd(8'h22, v); chk(v == 8'd200, "R9 ptr single frame", v, 200);
        rd(8'h01, v); chk(v == ((mdl_slot == 0) ? 8'h04 : 8'h08), "R9 single flag", v, 0);
        rd(8'h02, v); chk(v == 8'h00, "R9 idle", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule